// File: doc/BRIEF.md
# Beacon Message Field Packer

This block turns the three fields of a short beacon report into a single 50-bit word. The fields are a callsign of up to six characters, a four-character grid square and a transmit power in dBm. The callsign arrives already mapped to small codes, one code per character. The grid arrives as two letter indices and two digits. The power arrives as a signed byte. After a start pulse the block captures all inputs. It then folds the callsign into one integer through a chain of mixed-radix steps, one multiply-and-add per clock, and builds the grid index alongside it. In the last step it snaps the power onto the allowed ladder and presents the finished word together with a one-cycle done pulse.

The block is meant to sit in front of an encoder that needs the message in packed binary form. Only plain callsigns are handled, so the extra-type term in the power field is always zero. Every operation takes the same number of cycles, whatever the input.

Top module: `beacon_packer`

## Requirements
- R1: Character codes are 0-9 for digits '0'-'9', 10-35 for letters 'A'-'Z' and 36 for space. Character k occupies bits [6k+5:6k] of callChars, with k=0 the leftmost character. The area digit is taken at position 2 if that character is a digit, otherwise at position 1 if that character is a digit, otherwise at position 0. The callsign is right-aligned so that this digit becomes its third symbol, and missing leading symbols take the value 36.
- R2: The callsign value is built as v=s0, then v=36*v+s1, then v=10*v+s2, then three times v=27*v+t, where t is the letter index (code-10) of the following character, or 26 when that character is a space or lies beyond the sixth.
- R3: With grid letters A and B given as indices 0-17 and grid digits C and D given as 0-9, the grid index is 180*(179-10*A-C)+10*B+D.
- R4: A power below 0 is treated as 0 and a power above 60 is treated as 60.
- R5: A power p in 0..60 is corrected by adding an amount chosen by p mod 10 from {0:0, 1:-1, 2:+1, 3:0, 4:-1, 5:+2, 6:+1, 7:0, 8:-1, 9:+1}.
- R6: The low 22-bit field is the grid index shifted left by 7, ORed with the corrected power plus 64.
- R7: packedWord[49:22] holds the 28-bit callsign value and packedWord[21:0] holds the 22-bit field.
- R8: done is high for exactly one cycle, 7 clock edges after the edge at which start was accepted. A start held high continuously is accepted every 8 edges.
- R9: start is ignored while an operation is in progress, including the edge at which done is raised. All inputs are captured at acceptance, so changes made later do not affect the result.
- R10: During and after reset, done is 0 and packedWord is 0.
- R11: packedWord keeps its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to pack the current inputs |
| callChars | input | 36 | Six mapped callsign character codes |
| gridLetterA | input | 5 | First grid letter index, 0-17 |
| gridLetterB | input | 5 | Second grid letter index, 0-17 |
| gridDigitC | input | 4 | First grid digit, 0-9 |
| gridDigitD | input | 4 | Second grid digit, 0-9 |
| powerDbm | input | 8 | Signed transmit power in dBm |
| packedWord | output | 50 | Packed message word |
| done | output | 1 | One-cycle pulse when packedWord is new |

## Verification
The assertions check, on every cycle, that done never lasts two cycles and that packedWord changes only together with done. They also check that each packed field stays within its legal range and that the step counter advances without a gap once an operation has started. The values themselves can only be shown by the bench's scenarios. These cover the alignment choice for each position of the area digit, empty letter slots, both power clamps and the correction table, the two extreme grid squares, starts and input changes during an operation, and a start held high across several operations. All of them are compared cycle by cycle against a behavioural model.

// File: rtl/beacon_pkg.sv
package beacon_pkg;
  localparam int NUM_CHARS      = 6;
  localparam int CHAR_W         = 6;
  localparam int CALL_BITS      = 28;
  localparam int LOC_BITS       = 15;
  localparam int PWR_FIELD_BITS = 7;
  localparam int PWR_IN_W       = 8;
  localparam int GRID_LTR_W     = 5;
  localparam int GRID_DIG_W     = 4;
  localparam int NUM_STEPS      = 6;
  localparam int STEP_W         = $clog2(NUM_STEPS + 1);
  localparam int WORD_BITS      = CALL_BITS + LOC_BITS + PWR_FIELD_BITS;
  localparam int CHAR_SPACE     = 36;
  localparam int LETTER_EMPTY   = 26;
  localparam int PWR_MAX        = 60;
  localparam int PWR_OFFSET     = 64;

  typedef struct packed {
    logic              capture;
    logic              advance;
    logic [STEP_W-1:0] stepIdx;
    logic              finish;
  } strobe_t;

  // Correction added to a power value, chosen by its last decimal digit
  function automatic int powerCorr(input int lastDigit);
    case (lastDigit)
      1, 4, 8: powerCorr = -1;
      2, 6, 9: powerCorr = 1;
      5:       powerCorr = 2;
      default: powerCorr = 0;
    endcase
  endfunction
endpackage

// File: rtl/beacon_ctrl.sv
module beacon_ctrl
  import beacon_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t strobes
);
  localparam logic [STEP_W-1:0] LAST_PHASE = STEP_W'(NUM_STEPS);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t            state;
  logic [STEP_W-1:0] stepCnt;

  always_comb begin
    strobes = '0;
    if (state == ST_IDLE) begin
      strobes.capture = start;
    end else if (stepCnt < LAST_PHASE) begin
      strobes.advance = 1'b1;
      strobes.stepIdx = stepCnt;
    end else begin
      strobes.finish = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        state   <= ST_RUN;
        stepCnt <= '0;
      end
    end else if (stepCnt == LAST_PHASE) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  // R9: once running, the sequence runs to its end without a pause or restart
  a_r9_run_continues: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && stepCnt != LAST_PHASE) |=>
      (state == ST_RUN && stepCnt == $past(stepCnt) + 1'b1));

  // R8: the finishing phase always hands back to idle
  a_r8_finish_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> (state == ST_IDLE));
endmodule

// File: rtl/beacon_datapath.sv
module beacon_datapath
  import beacon_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strobes,
  input  logic [NUM_CHARS*CHAR_W-1:0]    callChars,
  input  logic [GRID_LTR_W-1:0]          gridLetterA,
  input  logic [GRID_LTR_W-1:0]          gridLetterB,
  input  logic [GRID_DIG_W-1:0]          gridDigitC,
  input  logic [GRID_DIG_W-1:0]          gridDigitD,
  input  logic signed [PWR_IN_W-1:0]     powerDbm,
  output logic [WORD_BITS-1:0]           packedWord,
  output logic                           done
);
  localparam int FIELD_LO = PWR_FIELD_BITS;
  localparam int CALL_LO  = PWR_FIELD_BITS + LOC_BITS;
  localparam longint CALL_MAX = 262374389;
  localparam int LOC_MAX  = 32399;

  logic [CHAR_W-1:0]           charReg [NUM_CHARS];
  logic [GRID_LTR_W-1:0]       ltrA, ltrB;
  logic [GRID_DIG_W-1:0]       digC, digD;
  logic signed [PWR_IN_W-1:0]  powerReg;
  logic [CALL_BITS-1:0]        acc;
  logic [LOC_BITS-1:0]         loc;

  // Capture registers, one per callsign character
  for (genvar k = 0; k < NUM_CHARS; k++) begin : g_charCap
    always_ff @(posedge clk) begin
      if (!rstN)                charReg[k] <= CHAR_W'(CHAR_SPACE);
      else if (strobes.capture) charReg[k] <= callChars[k*CHAR_W +: CHAR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ltrA <= '0; ltrB <= '0; digC <= '0; digD <= '0; powerReg <= '0;
    end else if (strobes.capture) begin
      ltrA <= gridLetterA; ltrB <= gridLetterB;
      digC <= gridDigitC;  digD <= gridDigitD;
      powerReg <= powerDbm;
    end
  end

  // Alignment: pick the area digit and right-align around it
  logic [1:0]        areaPos;
  logic [CHAR_W-1:0] aligned [NUM_CHARS];
  logic [CHAR_W-1:0] sfxIdx  [3];

  always_comb begin
    if (charReg[2] < CHAR_W'(10))      areaPos = 2'd2;
    else if (charReg[1] < CHAR_W'(10)) areaPos = 2'd1;
    else                               areaPos = 2'd0;
    for (int k = 0; k < NUM_CHARS; k++) begin
      int srcIdx;
      srcIdx = k + int'(areaPos) - 2;
      if (srcIdx < 0 || srcIdx >= NUM_CHARS) aligned[k] = CHAR_W'(CHAR_SPACE);
      else                                   aligned[k] = charReg[srcIdx];
    end
    for (int k = 0; k < 3; k++) begin
      if (aligned[k+3] == CHAR_W'(CHAR_SPACE)) sfxIdx[k] = CHAR_W'(LETTER_EMPTY);
      else                                     sfxIdx[k] = aligned[k+3] - CHAR_W'(10);
    end
  end

  // One multiply-and-add per step
  logic [CALL_BITS-1:0] accNext;
  logic [LOC_BITS-1:0]  locNext;

  always_comb begin
    accNext = acc;
    locNext = loc;
    case (strobes.stepIdx)
      STEP_W'(0): begin
        accNext = CALL_BITS'(aligned[0]);
        locNext = LOC_BITS'(179) - LOC_BITS'(10) * LOC_BITS'(ltrA) - LOC_BITS'(digC);
      end
      STEP_W'(1): begin
        accNext = acc * CALL_BITS'(36) + CALL_BITS'(aligned[1]);
        locNext = loc * LOC_BITS'(180) + LOC_BITS'(10) * LOC_BITS'(ltrB) + LOC_BITS'(digD);
      end
      STEP_W'(2): accNext = acc * CALL_BITS'(10) + CALL_BITS'(aligned[2]);
      STEP_W'(3): accNext = acc * CALL_BITS'(27) + CALL_BITS'(sfxIdx[0]);
      STEP_W'(4): accNext = acc * CALL_BITS'(27) + CALL_BITS'(sfxIdx[1]);
      STEP_W'(5): accNext = acc * CALL_BITS'(27) + CALL_BITS'(sfxIdx[2]);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      loc <= '0;
    end else if (strobes.advance) begin
      acc <= accNext;
      loc <= locNext;
    end
  end

  // Power: clamp, then snap with the last-digit correction
  logic [PWR_FIELD_BITS-1:0] pwrField;

  always_comb begin
    int pwrInt;
    int pwrAdj;
    pwrInt = int'(powerReg);
    if (pwrInt < 0)            pwrAdj = 0;
    else if (pwrInt > PWR_MAX) pwrAdj = PWR_MAX;
    else                       pwrAdj = pwrInt + powerCorr(pwrInt % 10);
    pwrField = PWR_FIELD_BITS'(pwrAdj + PWR_OFFSET);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      packedWord <= '0;
      done       <= 1'b0;
    end else begin
      done <= strobes.finish;
      if (strobes.finish) packedWord <= {acc, loc, pwrField};
    end
  end

  // R8: done never lasts two cycles
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: the output word changes only together with done
  a_r11_word_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(packedWord));

  // R5: the power part of a finished word lies on the corrected ladder plus offset
  a_r5_power_range: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (packedWord[FIELD_LO-1:0] >= PWR_FIELD_BITS'(PWR_OFFSET) &&
              packedWord[FIELD_LO-1:0] <= PWR_FIELD_BITS'(PWR_OFFSET + PWR_MAX)));

  // R3: the grid index never exceeds its largest legal value
  a_r3_loc_range: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (packedWord[CALL_LO-1:FIELD_LO] <= LOC_BITS'(LOC_MAX)));

  // R2: the callsign value never exceeds its largest legal value
  a_r2_call_range: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (packedWord[WORD_BITS-1:CALL_LO] <= CALL_BITS'(CALL_MAX)));
endmodule

// File: rtl/beacon_packer.sv
module beacon_packer
  import beacon_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic [NUM_CHARS*CHAR_W-1:0]    callChars,
  input  logic [GRID_LTR_W-1:0]          gridLetterA,
  input  logic [GRID_LTR_W-1:0]          gridLetterB,
  input  logic [GRID_DIG_W-1:0]          gridDigitC,
  input  logic [GRID_DIG_W-1:0]          gridDigitD,
  input  logic signed [PWR_IN_W-1:0]     powerDbm,
  output logic [WORD_BITS-1:0]           packedWord,
  output logic                           done
);
  strobe_t strobes;

  beacon_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes)
  );

  beacon_datapath i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .callChars   (callChars),
    .gridLetterA (gridLetterA),
    .gridLetterB (gridLetterB),
    .gridDigitC  (gridDigitC),
    .gridDigitD  (gridDigitD),
    .powerDbm    (powerDbm),
    .packedWord  (packedWord),
    .done        (done)
  );
endmodule

// File: tb/test_beacon_packer.sv
module test_beacon_packer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [35:0] callChars = '0;
  logic [4:0]  gridLetterA = '0, gridLetterB = '0;
  logic [3:0]  gridDigitC = '0, gridDigitD = '0;
  logic signed [7:0] powerDbm = '0;
  logic [49:0] packedWord;
  logic        done;

  int vectors = 0;
  int miscompares = 0;
  string curTag = "R10";
  bit   checking = 1'b0;

  always #5 clk = ~clk;

  beacon_packer i_beacon_packer (
    .clk(clk), .rstN(rstN), .start(start), .callChars(callChars),
    .gridLetterA(gridLetterA), .gridLetterB(gridLetterB),
    .gridDigitC(gridDigitC), .gridDigitD(gridDigitD),
    .powerDbm(powerDbm), .packedWord(packedWord), .done(done)
  );

  function automatic int charCode(input byte ch);
    if (ch >= "0" && ch <= "9") return ch - "0";
    if (ch >= "A" && ch <= "Z") return ch - "A" + 10;
    return 36;
  endfunction

  function automatic logic [35:0] callOf(input string s);
    logic [35:0] r;
    for (int k = 0; k < 6; k++) r[k*6 +: 6] = 6'(charCode(s[k]));
    return r;
  endfunction

  // Behavioural reference built from the requirements
  function automatic longint refPack(input logic [35:0] cc, input int a, input int b,
                                     input int c, input int d, input int pwr);
    int code [6];
    int pos, s0, s1, s2;
    longint v, g;
    int p;
    int corr [10] = '{0, -1, 1, 0, -1, 2, 1, 0, -1, 1};
    for (int k = 0; k < 6; k++) code[k] = int'(cc[k*6 +: 6]);
    pos = (code[2] < 10) ? 2 : (code[1] < 10) ? 1 : 0;
    s0 = (pos < 2) ? 36 : code[pos-2];
    s1 = (pos < 1) ? 36 : code[pos-1];
    s2 = code[pos];
    v = s0;
    v = 36 * v + s1;
    v = 10 * v + s2;
    for (int k = 1; k <= 3; k++) begin
      int t;
      t = (pos + k > 5 || code[pos+k] == 36) ? 26 : code[pos+k] - 10;
      v = 27 * v + t;
    end
    g = 180 * (179 - 10 * a - c) + 10 * b + d;
    if (pwr < 0) p = 0;
    else if (pwr > 60) p = 60;
    else p = pwr + corr[pwr % 10];
    return (v << 22) | (g << 7) | longint'(p + 64);
  endfunction

  // Cycle model: countdown of the operation in flight
  int     modelCnt = 0;
  bit     expDone = 1'b0;
  longint expPending = 0;
  longint expWord = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      modelCnt = 0; expDone = 1'b0; expWord = 0;
    end else begin
      expDone = (modelCnt == 1);
      if (expDone) expWord = expPending;
      if (modelCnt > 0) modelCnt = modelCnt - 1;
      else if (start) begin
        modelCnt = 7;
        expPending = refPack(callChars, int'(gridLetterA), int'(gridLetterB),
                             int'(gridDigitC), int'(gridDigitD), int'(powerDbm));
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      vectors++;
      if (done !== expDone || packedWord !== 50'(expWord)) begin
        miscompares++;
        $display("FAIL %s: done=%0b packedWord=%h expected done=%0b packedWord=%h",
                 curTag, done, packedWord, expDone, 50'(expWord));
      end
    end
  end

  task automatic directCheck(input string tag, input longint actual, input longint expected);
    vectors++;
    if (actual != expected) begin
      miscompares++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic setInputs(input string s, input int a, input int b, input int c,
                           input int d, input int pwr);
    callChars   = callOf(s);
    gridLetterA = 5'(a); gridLetterB = 5'(b);
    gridDigitC  = 4'(c); gridDigitD  = 4'(d);
    powerDbm    = 8'(pwr);
  endtask

  task automatic runOp(input string tag, input string s, input int a, input int b,
                       input int c, input int d, input int pwr);
    curTag = tag;
    @(negedge clk);
    setInputs(s, a, b, c, d, pwr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    directCheck(tag, longint'(packedWord), refPack(callOf(s), a, b, c, d, pwr));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stimulus
    int doneCount;
    repeat (3) @(negedge clk);
    // R10: reset values
    directCheck("R10", longint'(done), 0);
    directCheck("R10", longint'(packedWord), 0);
    rstN = 1'b1;
    checking = 1'b1;
    @(negedge clk);

    // R1/R2: digit at position 1, leading slot empty -> 36
    runOp("R1", "K1ABC ", 0, 0, 0, 0, 35);
    directCheck("R2", longint'(packedWord[49:22]), 259047992);
    directCheck("R5", longint'(packedWord[6:0]), 101);
    directCheck("R3", longint'(packedWord[21:7]), 32220);
    // R1: digit at position 2
    runOp("R1", "AB1CDE", 5, 7, 3, 4, 20);
    // R1: digit only at position 0, two leading slots empty
    runOp("R1", "7QRS  ", 9, 2, 8, 1, 13);
    // R2: empty trailing letter slots -> 26
    runOp("R2", "AB1C  ", 3, 3, 3, 3, 0);
    // R3: extreme grid squares
    runOp("R3", "W1AW  ", 17, 17, 9, 9, 10);
    directCheck("R3", longint'(packedWord[21:7]), 179);
    runOp("R6", "N0XYZ ", 0, 17, 0, 9, 37);
    // R4: clamps
    runOp("R4", "G4ABC ", 4, 4, 4, 4, -5);
    directCheck("R4", longint'(packedWord[6:0]), 64);
    runOp("R4", "G4ABC ", 4, 4, 4, 4, 75);
    directCheck("R4", longint'(packedWord[6:0]), 124);
    // R5: correction table across last digits
    for (int pw = 0; pw <= 60; pw += 7) runOp("R5", "VK2ZZ ", 11, 5, 2, 6, pw);
    runOp("R5", "VK2ZZ ", 11, 5, 2, 6, 59);
    directCheck("R5", longint'(packedWord[6:0]), 124);
    runOp("R5", "VK2ZZ ", 11, 5, 2, 6, 34);
    directCheck("R5", longint'(packedWord[6:0]), 97);
    // R7: field positions checked via full-word compares above; one more word
    runOp("R7", "ZZ9ZZZ", 1, 16, 5, 0, 47);

    // R9: a second start and new inputs during an operation are ignored
    curTag = "R9";
    @(negedge clk);
    setInputs("DL1ABC", 6, 8, 2, 2, 30);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    setInputs("JA3XYZ", 2, 1, 7, 7, 50);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    directCheck("R9", longint'(packedWord), refPack(callOf("DL1ABC"), 6, 8, 2, 2, 30));
    // R11: word holds while idle
    repeat (5) @(negedge clk);
    directCheck("R11", longint'(packedWord), refPack(callOf("DL1ABC"), 6, 8, 2, 2, 30));

    // R8: start held high -> one accepted start every 8 edges
    curTag = "R8";
    doneCount = 0;
    setInputs("F5ABC ", 7, 9, 1, 1, 23);
    start = 1'b1;
    for (int cyc = 0; cyc < 24; cyc++) begin
      @(negedge clk);
      if (done) doneCount++;
    end
    start = 1'b0;
    directCheck("R8", doneCount, 3);
    repeat (10) @(negedge clk);

    checking = 1'b0;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule